// File: doc/BRIEF.md
# Vectored Interrupt Receive Latch

This block receives one level-sensitive vectored interrupt line together with a source number. When the line rises and no vector is held, it captures the vector into a single-entry holding slot. In the same clock edge it raises a busy flag and a hard-interrupt request, sets the dispatch trap type to the vectored-interrupt code, and gives a one-cycle wake pulse that brings a halted core back to life. It also fills three 64-bit payload words. The first word carries a fixed 5-bit tag of all ones at bits 10..6 and the source number at bits 5..0. The other two words are zero.

When the line falls while a vector is held, the busy flag and the request are withdrawn. The payload words and the trap type keep their last values. While a vector is held, further activity on the line is ignored without any error indication. This includes a new source number presented while the line stays high.

An optional synchronizer depth on the line and source inputs is set by a parameter. With the default of zero stages, the inputs are taken as already synchronous.

Top module: `vil_latch_top`

## Requirements
- R1: After reset, busy, hard_req, wake and trap_type are 0, and all three payload words are 0.
- R2: On the first clock edge that samples the line high after it was low, with busy clear, busy and hard_req become 1 and trap_type becomes 0x60.
- R3: On that acceptance, vec_word0 becomes (0x1F << 6) | source, with the tag in bits 10..6 and the 6-bit source in bits 5..0. vec_word1 and vec_word2 become 0.
- R4: wake is 1 for exactly the one cycle following an acceptance and is 0 at all other times.
- R5: On the first edge that samples the line low after it was high, with busy set, busy and hard_req return to 0. The payload words and trap_type keep their values.
- R6: While busy, a change of the source number with the line held high does not alter the payload words, and does not produce a wake pulse.
- R7: With busy clear and no rising level, busy, hard_req and wake stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| irq_lvl | input | 1 | Vectored interrupt level |
| irq_src | input | 6 | Source number carried with the level |
| busy | output | 1 | A vector is held |
| hard_req | output | 1 | Hard-interrupt request to the core |
| trap_type | output | 9 | Dispatch trap type, 0x60 once a vector is accepted |
| vec_word0 | output | 64 | Payload word 0: tag and source |
| vec_word1 | output | 64 | Payload word 1, zero on acceptance |
| vec_word2 | output | 64 | Payload word 2, zero on acceptance |
| wake | output | 1 | One-cycle pulse that clears the core's halted state |

## Verification
With the default zero synchronizer stages, every output reflects a level change at the very edge that first samples it. Busy, request, trap type, payload and wake are therefore all due one clock after the input is driven. The driver applies each stimulus half a period before an edge and queues the expected output set for that edge. A monitor then compares one queued item a short delay after each rising edge, so exactly one edge separates stimulus from comparison. The falling-level and source-change cases are queued in the same way, so the retained payload is compared in the same cycle the release or ignored change takes effect.

// File: rtl/vil_pkg.sv
package vil_pkg;
   // Action decoded by the controller in a given cycle
   typedef enum logic [1:0] {
      VIL_ACT_NONE   = 2'd0,
      VIL_ACT_ACCEPT = 2'd1,
      VIL_ACT_DROP   = 2'd2
   } vil_act_e;

   localparam int VIL_NUM_WORDS = 3;

   function automatic logic [63:0] vil_tagged(input logic [4:0] tag, input int shift,
                                              input logic [63:0] src);
      logic [63:0] t;
      t = 64'(tag) << shift;
      return t | src;
   endfunction
endpackage

// File: rtl/vil_sync.sv
module vil_sync #(
   parameter int W      = 1,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("vil_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_st
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe[i] <= '0;
            end else if (i == 0) begin
               pipe[i] <= d;
            end else begin
               pipe[i] <= pipe[(i == 0) ? 0 : i-1];
            end
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/vil_edge.sv
module vil_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/vil_ctrl.sv
module vil_ctrl
   import vil_pkg::*;
#(
   parameter int          TRAP_W    = 9,
   parameter logic [TRAP_W-1:0] TRAP_CODE = 9'h060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   output vil_act_e          act,
   output logic              busy,
   output logic              hard_req,
   output logic [TRAP_W-1:0] trap_type,
   output logic              wake
);
   logic busy_q, req_q, wake_q;
   logic [TRAP_W-1:0] trap_q;

   always_comb begin
      act = VIL_ACT_NONE;
      if (rise && !busy_q)      act = VIL_ACT_ACCEPT;
      else if (fall && busy_q)  act = VIL_ACT_DROP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         req_q  <= 1'b0;
         wake_q <= 1'b0;
         trap_q <= '0;
      end else begin
         wake_q <= 1'b0;
         unique case (act)
            VIL_ACT_ACCEPT: begin
               busy_q <= 1'b1;
               req_q  <= 1'b1;
               wake_q <= 1'b1;
               trap_q <= TRAP_CODE;
            end
            VIL_ACT_DROP: begin
               busy_q <= 1'b0;
               req_q  <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign busy      = busy_q;
   assign hard_req  = req_q;
   assign trap_type = trap_q;
   assign wake      = wake_q;
endmodule

// File: rtl/vil_payload.sv
module vil_payload
   import vil_pkg::*;
#(
   parameter int       DATA_W    = 64,
   parameter int       SRC_W     = 6,
   parameter int       TAG_SHIFT = 6,
   parameter logic [4:0] TAG     = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  vil_act_e          act,
   input  logic [SRC_W-1:0]  src,
   output logic [DATA_W-1:0] word [VIL_NUM_WORDS]
);
   localparam int TAG_TOP = TAG_SHIFT + 5;

   if (TAG_TOP > DATA_W) begin : g_bad_fit
      $error("vil_payload: tag field exceeds word width");
   end
   if (SRC_W > TAG_SHIFT) begin : g_bad_src
      $error("vil_payload: source overlaps tag field");
   end

   logic [63:0] first_val;
   assign first_val = vil_tagged(TAG, TAG_SHIFT, 64'(src));

   for (genvar w = 0; w < VIL_NUM_WORDS; w++) begin : g_word
      logic [DATA_W-1:0] load_val;
      if (w == 0) begin : g_tagged
         assign load_val = first_val[DATA_W-1:0];
      end else begin : g_zero
         assign load_val = '0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                      word[w] <= '0;
         else if (act == VIL_ACT_ACCEPT)  word[w] <= load_val;
      end
   end
endmodule

// File: rtl/vil_latch_top.sv
module vil_latch_top
   import vil_pkg::*;
#(
   parameter int SRC_W       = 6,
   parameter int DATA_W      = 64,
   parameter int TRAP_W      = 9,
   parameter int TRAP_CODE   = 'h60,
   parameter int TAG_SHIFT   = 6,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_lvl,
   input  logic [SRC_W-1:0]  irq_src,
   output logic              busy,
   output logic              hard_req,
   output logic [TRAP_W-1:0] trap_type,
   output logic [DATA_W-1:0] vec_word0,
   output logic [DATA_W-1:0] vec_word1,
   output logic [DATA_W-1:0] vec_word2,
   output logic              wake
);
   localparam int IN_W = SRC_W + 1;

   if (DATA_W > 64 || DATA_W < TAG_SHIFT + 5) begin : g_bad_w
      $error("vil_latch_top: DATA_W out of range");
   end
   if (TRAP_CODE >= (1 << TRAP_W)) begin : g_bad_trap
      $error("vil_latch_top: TRAP_CODE does not fit TRAP_W");
   end

   logic [IN_W-1:0]   in_s;
   logic              lvl_s;
   logic [SRC_W-1:0]  src_s;
   logic              rise, fall;
   vil_act_e          act;
   logic [DATA_W-1:0] words [VIL_NUM_WORDS];

   vil_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({irq_lvl, irq_src}), .q(in_s));
   assign lvl_s = in_s[IN_W-1];
   assign src_s = in_s[SRC_W-1:0];

   vil_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .rise(rise), .fall(fall));

   vil_ctrl #(.TRAP_W(TRAP_W), .TRAP_CODE(TRAP_W'(TRAP_CODE))) u_ctrl (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .act(act),
      .busy(busy), .hard_req(hard_req), .trap_type(trap_type), .wake(wake));

   vil_payload #(.DATA_W(DATA_W), .SRC_W(SRC_W), .TAG_SHIFT(TAG_SHIFT),
                 .TAG(5'h1F)) u_payload (
      .clk(clk), .rst_n(rst_n), .act(act), .src(src_s), .word(words));

   assign vec_word0 = words[0];
   assign vec_word1 = words[1];
   assign vec_word2 = words[2];
endmodule

// File: rtl/vil_latch_chk.sv
module vil_latch_chk #(
   parameter int SRC_W     = 6,
   parameter int DATA_W    = 64,
   parameter int TRAP_W    = 9,
   parameter int TRAP_CODE = 'h60,
   parameter int TAG_SHIFT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lvl,
   input logic [SRC_W-1:0]  src,
   input logic              busy,
   input logic              hard_req,
   input logic [TRAP_W-1:0] trap_type,
   input logic [DATA_W-1:0] w0,
   input logic [DATA_W-1:0] w1,
   input logic [DATA_W-1:0] w2,
   input logic              wake
);
   logic prev;
   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end
   logic up, dn;
   assign up = lvl & ~prev;
   assign dn = ~lvl & prev;

   logic [DATA_W-1:0] exp_w0;
   assign exp_w0 = (DATA_W'(5'h1F) << TAG_SHIFT) | DATA_W'(src);

   AST_ACCEPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !busy) |=> (busy && hard_req && trap_type == TRAP_W'(TRAP_CODE))); // R2
   AST_ACCEPT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !busy) |=> (w0 == $past(exp_w0) && w1 == '0 && w2 == '0)); // R3
   AST_WAKE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $rose(busy)); // R4
   AST_WAKE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake); // R4
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && busy) |=> (!busy && !hard_req && $stable(w0) && $stable(trap_type))); // R5
   AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dn) |=> (busy && $stable(w0) && !wake)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !up) |=> (!busy && !hard_req && !wake)); // R7
endmodule

bind vil_latch_top vil_latch_chk #(
   .SRC_W(SRC_W), .DATA_W(DATA_W), .TRAP_W(TRAP_W),
   .TRAP_CODE(TRAP_CODE), .TAG_SHIFT(TAG_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .src(src_s), .busy(busy),
   .hard_req(hard_req), .trap_type(trap_type), .w0(vec_word0),
   .w1(vec_word1), .w2(vec_word2), .wake(wake));

// File: tb/tb_vil_latch_top.sv
module tb_vil_latch_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_lvl = 1'b0;
   logic [5:0]  irq_src = '0;
   logic        busy, hard_req, wake;
   logic [8:0]  trap_type;
   logic [63:0] vec_word0, vec_word1, vec_word2;

   always #2.5 clk = ~clk;

   vil_latch_top dut (
      .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .irq_src(irq_src),
      .busy(busy), .hard_req(hard_req), .trap_type(trap_type),
      .vec_word0(vec_word0), .vec_word1(vec_word1), .vec_word2(vec_word2),
      .wake(wake));

   typedef struct {
      logic        busy, req, wake;
      logic [8:0]  trap;
      logic [63:0] w0;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0, failures = 0;
   bit done = 0;

   // Reference model state, built from the requirements
   logic m_prev = 0, m_busy = 0;
   logic [8:0]  m_trap = '0;
   logic [63:0] m_w0 = '0;

   task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Driver: apply at negedge, queue what the next rising edge must produce
   task automatic step(logic lvl, logic [5:0] src, string tag);
      exp_t e;
      logic acc;
      @(negedge clk);
      irq_lvl = lvl;
      irq_src = src;
      acc = lvl && !m_prev && !m_busy;
      e.wake = acc;
      if (acc) begin
         m_busy = 1;
         m_trap = 9'h060;
         m_w0   = (64'h1F << 6) | 64'(src);
      end else if (!lvl && m_prev && m_busy) begin
         m_busy = 0;
      end
      m_prev = lvl;
      e.busy = m_busy; e.req = m_busy; e.trap = m_trap; e.w0 = m_w0; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compare one item shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            cmp(e.tag, "busy", 64'(busy), 64'(e.busy));
            cmp(e.tag, "hard_req", 64'(hard_req), 64'(e.req));
            cmp(e.tag, "wake", 64'(wake), 64'(e.wake));
            cmp(e.tag, "trap_type", 64'(trap_type), 64'(e.trap));
            cmp(e.tag, "vec_word0", vec_word0, e.w0);
            cmp(e.tag, "vec_word1", vec_word1, 64'h0);
            cmp(e.tag, "vec_word2", vec_word2, 64'h0);
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      checks++;
      cmp("R1", "busy", 64'(busy), 0);
      cmp("R1", "hard_req", 64'(hard_req), 0);
      cmp("R1", "wake", 64'(wake), 0);
      cmp("R1", "trap_type", 64'(trap_type), 0);
      cmp("R1", "words", vec_word0 | vec_word1 | vec_word2, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R7: idle low, source changes do nothing
      step(0, 6'h11, "R7");
      step(0, 6'h2A, "R7");
      // R2 R3 R4: accept source 5 -> word0 0x7C5
      step(1, 6'h05, "R2_R3_R4");
      // R4 R6: held high, source changes ignored, no second wake
      step(1, 6'h3F, "R4_R6");
      step(1, 6'h00, "R6");
      // R5: release keeps payload and trap
      step(0, 6'h00, "R5");
      step(0, 6'h00, "R7");
      // R3 boundary: max source -> 0x7FF
      step(1, 6'h3F, "R3_max");
      step(0, 6'h3F, "R5");
      // R2 R3: immediate re-accept, source 0 -> 0x7C0
      step(1, 6'h00, "R2_R3_zero");
      step(1, 6'h15, "R6");
      step(0, 6'h15, "R5");
      step(0, 6'h00, "R7");
      step(1, 6'h2A, "R2_R3");
      step(0, 6'h2A, "R5");
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule